// File: doc/BRIEF.md
# UART Receive/Transmit Byte Queues with Trigger Control

This block holds the two byte queues that sit between a UART's serial shifters and its host bus: one queue collects received bytes, the other holds bytes waiting to be sent. A single 8-bit control word, written through a simple write strobe, switches the queues between deep-buffer operation and single-byte holding operation. The same word flushes either queue on demand, arms DMA requests and picks how full the receive queue must be before the host is alerted.

The receive side reports a trigger that serves as the interrupt source. It also reports a DMA request, which follows that trigger only when DMA operation is armed and the queues are enabled. A byte that arrives when no room is left is thrown away, and a sticky overrun flag records the loss until the host strobes a status read. The serial shifter, the baud generator, line framing and interrupt identification belong to neighbouring logic.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset both queues are empty, rx_count is 0, rx_trig, rx_dma_req and overrun are 0, and cfg_rdata reads 0.
- R2: With cfg bit 0 set, each queue holds up to DEPTH (16) bytes and returns them in arrival order. rx_count gives the number of bytes held, and the full flag rises when DEPTH bytes are held.
- R3: With cfg bit 0 clear, each queue holds at most one byte. A cfg write that changes bit 0 empties both queues on that clock edge.
- R4: A cfg write with bit 1 set empties the receive queue, and one with bit 2 set empties the transmit queue, on that clock edge. A push in the same cycle is discarded. Both bits read back as 0, and writing 0 to them leaves the contents alone.
- R5: With cfg bit 0 set, rx_trig is 1 while rx_count is at least the level chosen by cfg bits 7:6 (00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14). With bit 0 clear, rx_trig is 1 while one byte is held.
- R6: rx_dma_req equals rx_trig when cfg bits 3 and 0 are both set, and is 0 otherwise.
- R7: A receive push that finds the queue full and is not paired with a pop is dropped and sets overrun. overrun stays set until an ovr_clear strobe. If a new drop happens in the same cycle as ovr_clear, the flag stays set.
- R8: A push together with a pop on a full queue performs both, leaving the count unchanged and keeping order. A pop on an empty queue is ignored, so a push paired with it simply stores the byte.
- R9: A transmit push into a full transmit queue without a pop is dropped silently. The contents stay unchanged and overrun is not affected.
- R10: cfg_rdata shows the stored enable in bit 0, DMA arm in bit 3 and trigger select in bits 7:6. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| cfg_rdata | output | 8 | Stored control word |
| rx_push | input | 1 | Receive byte arriving from shifter |
| rx_din | input | 8 | Received byte |
| rx_pop | input | 1 | Host takes oldest received byte |
| rx_dout | output | 8 | Oldest received byte |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue at capacity |
| rx_count | output | 5 | Bytes held in receive queue |
| rx_trig | output | 1 | Receive trigger (interrupt source) |
| rx_dma_req | output | 1 | Receive DMA request |
| overrun | output | 1 | Sticky receive overrun flag |
| ovr_clear | input | 1 | Status-read strobe clearing overrun |
| tx_push | input | 1 | Host writes a byte to send |
| tx_din | input | 8 | Byte to send |
| tx_pop | input | 1 | Shifter takes oldest byte |
| tx_dout | output | 8 | Oldest byte waiting to send |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue at capacity |

## Verification
The hardest situations to reach are the ones at the capacity edge. Examples are a push paired with a pop on a queue that is exactly full, and a new drop coinciding with the clear strobe. Random traffic seldom keeps a 16-byte queue full for long, so directed sequences first fill the receive queue to the brim and then fire these combinations. After that, random phases with push-heavy bias and occasional control writes that toggle the enable or flush a queue keep revisiting the full and single-byte regimes. Every cycle is compared against a queue model held in the bench.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  // Stored part of the control word
  typedef struct packed {
    logic [1:0] trig_sel;
    logic       dma_arm;
    logic       q_en;
  } fcfg_t;

  // Receive trigger threshold for each select code
  function automatic logic [7:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   trig_level = 8'd1;
      2'b01:   trig_level = 8'd4;
      2'b10:   trig_level = 8'd8;
      default: trig_level = 8'd14;
    endcase
  endfunction

  // Layout of the control word as read back
  function automatic logic [7:0] cfg_pack(input fcfg_t c);
    cfg_pack = {c.trig_sel, 2'b00, c.dma_arm, 2'b00, c.q_en};
  endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          cap_one,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          drop
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cap;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    ptr_next = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign cap     = cap_one ? CW'(1) : CW'(DEPTH);
  assign empty   = (count == '0);
  assign full    = (count >= cap);
  assign do_pop  = pop & ~empty & ~flush;
  assign do_push = push & ~flush & (~full | do_pop);
  assign drop    = push & ~flush & ~do_push;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= ptr_next(wptr);
      if (do_pop)  rptr <= ptr_next(rptr);
      if (do_push && !do_pop)      count <= count + CW'(1);
      else if (do_pop && !do_push) count <= count - CW'(1);
    end
  end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          rx_push,
  input  logic [7:0]    rx_din,
  input  logic          rx_pop,
  output logic [7:0]    rx_dout,
  output logic          rx_empty,
  output logic          rx_full,
  output logic [CW-1:0] rx_count,
  output logic          rx_trig,
  output logic          rx_dma_req,
  output logic          overrun,
  input  logic          ovr_clear,
  input  logic          tx_push,
  input  logic [7:0]    tx_din,
  input  logic          tx_pop,
  output logic [7:0]    tx_dout,
  output logic          tx_empty,
  output logic          tx_full
);

  fcfg_t         cfg_q;
  logic          en_q, dma_q;
  logic          en_flip;
  logic          rx_flush, tx_flush;
  logic          rx_drop, tx_drop;
  logic [CW-1:0] level;
  logic [CW-1:0] tx_count;

  assign en_q  = cfg_q.q_en;
  assign dma_q = cfg_q.dma_arm;

  // Named flush events: explicit flush bit or a change of the enable
  assign en_flip  = cfg_we & (cfg_wdata[0] != en_q);
  assign rx_flush = (cfg_we & cfg_wdata[1]) | en_flip;
  assign tx_flush = (cfg_we & cfg_wdata[2]) | en_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q.q_en     <= cfg_wdata[0];
      cfg_q.dma_arm  <= cfg_wdata[3];
      cfg_q.trig_sel <= cfg_wdata[7:6];
    end
  end

  assign cfg_rdata = cfg_pack(cfg_q);

  uart_byte_fifo #(.DEPTH(DEPTH), .DW(8)) rx_q_i (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .cap_one(~en_q),
    .push(rx_push), .din(rx_din), .pop(rx_pop), .dout(rx_dout),
    .count(rx_count), .empty(rx_empty), .full(rx_full), .drop(rx_drop)
  );

  uart_byte_fifo #(.DEPTH(DEPTH), .DW(8)) tx_q_i (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .cap_one(~en_q),
    .push(tx_push), .din(tx_din), .pop(tx_pop), .dout(tx_dout),
    .count(tx_count), .empty(tx_empty), .full(tx_full), .drop(tx_drop)
  );

  // Trigger threshold: selected level in queue mode, one byte in holding mode
  assign level      = en_q ? CW'(trig_level(cfg_q.trig_sel)) : CW'(1);
  assign rx_trig    = (rx_count >= level);
  assign rx_dma_req = rx_trig & en_q & dma_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           overrun <= 1'b0;
    else if (rx_drop)     overrun <= 1'b1;
    else if (ovr_clear)   overrun <= 1'b0;
  end

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] rx_count,
  input logic          rx_push,
  input logic          rx_pop,
  input logic          rx_full,
  input logic          rx_flush,
  input logic          rx_drop,
  input logic          overrun,
  input logic          ovr_clear,
  input logic          rx_trig,
  input logic          rx_dma_req,
  input logic          en_q,
  input logic          dma_q,
  input logic          tx_full,
  input logic          tx_push,
  input logic          tx_pop,
  input logic          tx_flush
);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  assert_single_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> rx_count <= CW'(1));

  assert_rx_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> rx_count == '0);

  assert_top_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && rx_count >= CW'(14)) |-> rx_trig);

  assert_dma_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> (en_q && dma_q && rx_trig));

  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> overrun);

  assert_overrun_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clear) |=> overrun);

  assert_full_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_push && rx_pop && !rx_flush) |=> $stable(rx_count));

  assert_tx_stays_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_push && !tx_pop && !tx_flush) |=> tx_full);

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .rx_push(rx_push),
  .rx_pop(rx_pop), .rx_full(rx_full), .rx_flush(rx_flush), .rx_drop(rx_drop),
  .overrun(overrun), .ovr_clear(ovr_clear), .rx_trig(rx_trig),
  .rx_dma_req(rx_dma_req), .en_q(en_q), .dma_q(dma_q), .tx_full(tx_full),
  .tx_push(tx_push), .tx_pop(tx_pop), .tx_flush(tx_flush)
);

// File: tb/uart_fifo_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_fifo_ctrl_tb_top;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 0;
  logic [7:0] cfg_wdata = 0;
  logic [7:0] cfg_rdata;
  logic       rx_push = 0, rx_pop = 0, ovr_clear = 0;
  logic [7:0] rx_din = 0, rx_dout;
  logic       rx_empty, rx_full, rx_trig, rx_dma_req, overrun;
  logic [4:0] rx_count;
  logic       tx_push = 0, tx_pop = 0;
  logic [7:0] tx_din = 0, tx_dout;
  logic       tx_empty, tx_full;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_fifo_ctrl #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop),
    .rx_dout(rx_dout), .rx_empty(rx_empty), .rx_full(rx_full),
    .rx_count(rx_count), .rx_trig(rx_trig), .rx_dma_req(rx_dma_req),
    .overrun(overrun), .ovr_clear(ovr_clear), .tx_push(tx_push),
    .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout),
    .tx_empty(tx_empty), .tx_full(tx_full)
  );

  // Bench model
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  bit         m_en = 0, m_dma = 0, m_ov = 0;
  logic [1:0] m_sel = 0;

  function automatic int thresh(input logic [1:0] s);
    int lv[4] = '{1, 4, 8, 14};
    return lv[s];
  endfunction

  function automatic bit exp_trig();
    if (!m_en) return rxq.size() != 0;
    return rxq.size() >= thresh(m_sel);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int cap;
    cap = m_en ? DEPTH : 1;
    chk("R2", "rx_count", int'(rx_count), rxq.size());
    chk("R2", "rx_empty", int'(rx_empty), int'(rxq.size() == 0));
    chk("R3", "rx_full", int'(rx_full), int'(rxq.size() >= cap));
    chk("R9", "tx_empty", int'(tx_empty), int'(txq.size() == 0));
    chk("R9", "tx_full", int'(tx_full), int'(txq.size() >= cap));
    if (rxq.size() != 0) chk("R8", "rx_dout", int'(rx_dout), int'(rxq[0]));
    if (txq.size() != 0) chk("R8", "tx_dout", int'(tx_dout), int'(txq[0]));
    chk("R5", "rx_trig", int'(rx_trig), int'(exp_trig()));
    chk("R6", "rx_dma_req", int'(rx_dma_req), int'(exp_trig() && m_en && m_dma));
    chk("R7", "overrun", int'(overrun), int'(m_ov));
    chk("R10", "cfg_rdata", int'(cfg_rdata),
        int'({m_sel, 4'b0000, 1'b0, 1'b0}) + (m_dma ? 8 : 0) + (m_en ? 1 : 0));
  endtask

  // Apply one cycle of stimulus, advance the model, check after the edge
  task automatic step(input bit we, input logic [7:0] wd,
                      input bit rp, input logic [7:0] rd, input bit rpo,
                      input bit tp, input logic [7:0] td, input bit tpo,
                      input bit oc);
    bit fl_rx, fl_tx, popped, hold_en;
    int cap;
    cfg_we = we; cfg_wdata = wd; rx_push = rp; rx_din = rd; rx_pop = rpo;
    tx_push = tp; tx_din = td; tx_pop = tpo; ovr_clear = oc;
    hold_en = m_en;
    fl_rx = we && (wd[1] || (wd[0] != m_en));
    fl_tx = we && (wd[2] || (wd[0] != m_en));
    cap = hold_en ? DEPTH : 1;
    if (oc) m_ov = 0;
    if (fl_rx) rxq.delete();
    else begin
      popped = rpo && rxq.size() != 0;
      if (rp && !(rxq.size() < cap || popped)) m_ov = 1;
      if (popped) void'(rxq.pop_front());
      if (rp && (rxq.size() < cap)) rxq.push_back(rd);
    end
    if (fl_tx) txq.delete();
    else begin
      popped = tpo && txq.size() != 0;
      if (popped) void'(txq.pop_front());
      if (tp && (txq.size() < cap)) txq.push_back(td);
    end
    if (we) begin
      m_en = wd[0]; m_dma = wd[3]; m_sel = wd[7:6];
    end
    @(negedge clk);
    cfg_we = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0; ovr_clear = 0;
    compare_all();
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "rx_empty", int'(rx_empty), 1);
    chk("R1", "tx_empty", int'(tx_empty), 1);
    chk("R1", "rx_trig", int'(rx_trig), 0);
    chk("R1", "overrun", int'(overrun), 0);
    chk("R1", "cfg_rdata", int'(cfg_rdata), 0);
    compare_all();

    // R3: holding mode, second byte is dropped with overrun
    step(0, 0, 1, 8'h11, 0, 1, 8'h21, 0, 0);
    step(0, 0, 1, 8'h12, 0, 1, 8'h22, 0, 0);
    chk("R3", "single byte kept", int'(rx_dout), 8'h11);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);

    // Enable queues, trigger 14, DMA armed (flush via enable change)
    step(1, 8'hC9, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) step(0, 0, 1, 8'(8'h40 + i), 0, 1, 8'(8'h80 + i), 0, 0);
    chk("R5", "trig at full", int'(rx_trig), 1);
    chk("R6", "dma at full", int'(rx_dma_req), 1);
    // R8: push with pop on full queue
    step(0, 0, 1, 8'h99, 1, 1, 8'h98, 1, 0);
    chk("R8", "count kept", int'(rx_count), 16);
    // R7: drop, then drop coinciding with clear
    step(0, 0, 1, 8'h55, 0, 1, 8'h56, 0, 0);
    step(0, 0, 1, 8'h57, 0, 0, 0, 0, 1);
    chk("R7", "set wins over clear", int'(overrun), 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R4: write 0 to flush bits keeps contents, then flush rx only
    step(1, 8'hC1, 0, 0, 0, 0, 0, 0, 0);
    chk("R4", "no flush", int'(rx_count), 16);
    step(1, 8'h03, 1, 8'h77, 0, 0, 0, 0, 0);
    chk("R4", "rx flushed", int'(rx_count), 0);
    chk("R4", "tx kept", int'(tx_full), 1);
    step(1, 8'h05, 0, 0, 0, 0, 0, 0, 0);
    // R5: walk each trigger level
    for (int s = 0; s < 4; s++) begin
      step(1, 8'(8'h03 | (s << 6)), 0, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 15; i++) step(0, 0, 1, 8'(i), 0, 0, 0, 0, 0);
    end
    // R8: push with pop on empty queue
    step(1, 8'h03, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 1, 8'h3C, 1, 1, 8'h3D, 1, 0);

    // Random phases
    for (int ph = 0; ph < 6; ph++) begin
      int pp = (ph % 2 == 0) ? 70 : 35;
      for (int c = 0; c < 2000; c++) begin
        bit we = ($urandom_range(0, 99) < 2);
        logic [7:0] wd = 8'($urandom());
        if ($urandom_range(0, 7) != 0) wd[0] = 1'b1;
        if ($urandom_range(0, 3) != 0) wd[2:1] = 2'b00;
        step(we, wd,
             $urandom_range(0, 99) < pp, 8'($urandom()), $urandom_range(0, 99) < 50,
             $urandom_range(0, 99) < pp, 8'($urandom()), $urandom_range(0, 99) < 50,
             $urandom_range(0, 99) < 5);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule